// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block is the byte-level back end of a serial non-volatile memory slave. Once the bus front end has decoded a write command and its 16-bit start address, it hands this block a start strobe with the address, one strobe per received data byte, and a strobe when the bus stop condition is seen. The block gathers the bytes in a 64-byte page buffer. The address advances inside the page only, so a long burst wraps and overwrites earlier bytes. At stop, it commits the bytes that were actually received to an on-chip array during a timed write cycle, and a busy flag marks that cycle.

A write-protect input is looked at only on the stop cycle. A protected command is still taken in, but it is dropped without a write cycle. The address pointer survives each transaction so that a read front end can use it. A command that carries only an address sets the pointer and starts no write cycle, which is how a random read is set up. The read data output always shows the array byte at the pointer.

Top module: `pwb_page_writer`

## Requirements
- R1: After reset, `busy_o` is 0 and `ptr_o` is 0.
- R2: A `cmd_start_i` pulse while not busy loads `addr_i` into `ptr_o` on the next cycle and begins a new transaction. `rd_data_o` always shows the array byte at `ptr_o` (the array is indexed by the low ARRAY_AW pointer bits).
- R3: Each accepted data byte is stored at the pointer's page offset (bits 5:0), and then only bits 5:0 of the pointer increment. Bits 15:6 never change during a transaction.
- R4: If more than 64 bytes arrive before stop, the offset wraps from 63 to 0, and a later byte replaces the byte buffered earlier at the same offset.
- R5: A burst that starts mid-page and runs past offset 63 continues at offset 0 of the same page.
- R6: `busy_o` stays low while bytes arrive. It rises only in the cycle after a `stop_i` strobe.
- R7: A committing stop holds `busy_o` high for exactly WR_CYCLES clock cycles, starting the cycle after the stop strobe.
- R8: `wp_i` is sampled only on the stop cycle. If it is high there, `busy_o` never rises and the array is unchanged. A change of `wp_i` after a committing stop does not stop the write.
- R9: After a committed write, `ptr_o` holds the address that follows the last byte written, wrapped within the page.
- R10: Only offsets written in the current transaction are committed. Other bytes of the page keep their earlier array values.
- R11: A stop with no data byte in the transaction starts no write cycle and leaves `ptr_o` at the command address.
- R12: While `busy_o` is high, `cmd_start_i`, `data_valid_i` and `stop_i` are ignored. The pointer, the buffer and the array are not touched by them.
- R13: A data byte and `stop_i` in the same cycle: the byte is accepted first and is included in the commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_start_i | input | 1 | Write command decoded, start address valid |
| addr_i | input | 16 | Start address of the command |
| data_valid_i | input | 1 | One received data byte on data_i |
| data_i | input | 8 | Data byte |
| stop_i | input | 1 | Bus stop condition seen |
| wp_i | input | 1 | Write-protect level, sampled at stop |
| busy_o | output | 1 | Internal write cycle in progress |
| ptr_o | output | 16 | Internal address pointer |
| rd_data_o | output | 8 | Array byte at the pointer |

## Verification
Two functions can fall in the same cycle here. Byte capture and the commit decision coincide when the last data byte and the stop strobe are driven together. Separately, new bus activity can overlap a running write cycle. The first case is provoked by raising `data_valid_i` and `stop_i` on one clock. It is judged by reading back that both bytes reached the array and that the pointer moved past the final byte. The second case is provoked by issuing a full command, a byte and a stop while `busy_o` is high. It is judged by a stable `ptr_o` and by the target address keeping its older contents once the cycle ends.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RX    = 2'd1,
    ST_WRITE = 2'd2
  } wr_state_e;
endpackage

// File: rtl/pwb_buf.sv
module pwb_buf #(
  parameter int PAGE_BYTES = 64,
  parameter int PAGE_AW    = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               we_i,
  input  logic [PAGE_AW-1:0] widx_i,
  input  logic [7:0]         wdata_i,
  input  logic [PAGE_AW-1:0] ridx_i,
  output logic [7:0]         rdata_o,
  output logic               rvalid_o
);
  logic [7:0]            data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_w;

  always_ff @(posedge clk_i) begin
    if (we_i) data_q[widx_i] <= wdata_i;
  end

  // per-byte valid flag, cleared on each new command
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_mask
    logic v_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                v_q <= 1'b0;
      else if (clr_i)                             v_q <= 1'b0;
      else if (we_i && widx_i == PAGE_AW'(g))     v_q <= 1'b1;
    end
    assign mask_w[g] = v_q;
  end

  assign rdata_o  = data_q[ridx_i];
  assign rvalid_o = mask_w[ridx_i];

  // R10
  mask_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !we_i |=> mask_w == '0);
endmodule

// File: rtl/pwb_array.sv
module pwb_array #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PAGE_AW   = 6,
  parameter int WR_CYCLES = 200
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_start_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               data_valid_i,
  input  logic               stop_i,
  input  logic               wp_i,
  output logic               busy_o,
  output logic [ADDR_W-1:0]  ptr_o,
  output logic               buf_we_o,
  output logic               buf_clr_o,
  output logic               commit_en_o,
  output logic [PAGE_AW-1:0] commit_idx_o
);
  localparam int TMR_W = $clog2(WR_CYCLES);

  wr_state_e          state_q;
  logic [ADDR_W-1:0]  ptr_q;
  logic               has_q;
  logic [TMR_W-1:0]   tmr_q;
  logic [PAGE_AW:0]   cidx_q;

  logic cmd_ok, byte_ok, stop_ok, go_write;

  assign cmd_ok   = cmd_start_i && (state_q != ST_WRITE);
  assign byte_ok  = data_valid_i && (state_q == ST_RX) && !cmd_start_i;
  assign stop_ok  = stop_i && (state_q == ST_RX) && !cmd_start_i;
  // byte in the stop cycle counts as data
  assign go_write = stop_ok && (has_q || byte_ok) && !wp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      has_q   <= 1'b0;
      tmr_q   <= '0;
      cidx_q  <= '0;
    end else if (cmd_ok) begin
      state_q <= ST_RX;
      ptr_q   <= addr_i;
      has_q   <= 1'b0;
    end else begin
      if (byte_ok) begin
        ptr_q[PAGE_AW-1:0] <= ptr_q[PAGE_AW-1:0] + PAGE_AW'(1);
        has_q              <= 1'b1;
      end
      if (stop_ok) begin
        state_q <= go_write ? ST_WRITE : ST_IDLE;
        tmr_q   <= TMR_W'(WR_CYCLES - 1);
        cidx_q  <= '0;
      end
      if (state_q == ST_WRITE) begin
        if (tmr_q == '0) state_q <= ST_IDLE;
        else             tmr_q   <= tmr_q - 1'b1;
        if (!cidx_q[PAGE_AW]) cidx_q <= cidx_q + 1'b1;
      end
    end
  end

  assign busy_o       = (state_q == ST_WRITE);
  assign ptr_o        = ptr_q;
  assign buf_we_o     = byte_ok;
  assign buf_clr_o    = cmd_ok;
  assign commit_en_o  = (state_q == ST_WRITE) && !cidx_q[PAGE_AW];
  assign commit_idx_o = cidx_q[PAGE_AW-1:0];

  // R6
  busy_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));
  // R8
  wp_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && wp_i && !busy_o |=> !busy_o);
  // R11
  empty_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && (state_q == ST_RX) && !has_q && !data_valid_i && !cmd_start_i |=> !busy_o);
  // R3
  page_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_i && !busy_o && !cmd_start_i
      |=> ptr_o[ADDR_W-1:PAGE_AW] == $past(ptr_o[ADDR_W-1:PAGE_AW]));
  // R12
  busy_ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(ptr_o));
endmodule

// File: rtl/pwb_page_writer.sv
module pwb_page_writer #(
  parameter int ADDR_W     = 16,
  parameter int ARRAY_AW   = 10,
  parameter int PAGE_BYTES = 64,
  parameter int WR_CYCLES  = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_valid_i,
  input  logic [7:0]        data_i,
  input  logic              stop_i,
  input  logic              wp_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [7:0]        rd_data_o
);
  localparam int PAGE_AW = $clog2(PAGE_BYTES);

  logic               buf_we, buf_clr, commit_en, buf_valid;
  logic [PAGE_AW-1:0] commit_idx;
  logic [7:0]         buf_data;
  logic [ADDR_W-1:0]  ptr;

  pwb_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW), .WR_CYCLES(WR_CYCLES)
  ) u_ctrl (
    .clk_i, .rst_ni, .cmd_start_i, .addr_i, .data_valid_i, .stop_i, .wp_i,
    .busy_o,
    .ptr_o        (ptr),
    .buf_we_o     (buf_we),
    .buf_clr_o    (buf_clr),
    .commit_en_o  (commit_en),
    .commit_idx_o (commit_idx)
  );

  pwb_buf #(
    .PAGE_BYTES(PAGE_BYTES), .PAGE_AW(PAGE_AW)
  ) u_buf (
    .clk_i, .rst_ni,
    .clr_i    (buf_clr),
    .we_i     (buf_we),
    .widx_i   (ptr[PAGE_AW-1:0]),
    .wdata_i  (data_i),
    .ridx_i   (commit_idx),
    .rdata_o  (buf_data),
    .rvalid_o (buf_valid)
  );

  pwb_array #(.AW(ARRAY_AW)) u_array (
    .clk_i,
    .we_i    (commit_en && buf_valid),
    .waddr_i ({ptr[ARRAY_AW-1:PAGE_AW], commit_idx}),
    .wdata_i (buf_data),
    .raddr_i (ptr[ARRAY_AW-1:0]),
    .rdata_o (rd_data_o)
  );

  assign ptr_o = ptr;
endmodule

// File: tb/pwb_page_writer_test.sv
module pwb_page_writer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WR         = 70;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_start_i = 0, data_valid_i = 0, stop_i = 0, wp_i = 0;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        busy_o;
  logic [15:0] ptr_o;
  logic [7:0]  rd_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwb_page_writer #(.WR_CYCLES(WR)) uut (
    .clk_i(clk), .rst_ni, .cmd_start_i, .addr_i, .data_valid_i, .data_i,
    .stop_i, .wp_i, .busy_o, .ptr_o, .rd_data_o
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural model
  logic [7:0]  m_mem [1024];
  logic [7:0]  m_buf [64];
  logic [63:0] m_mask;
  logic [15:0] m_ptr;
  bit          m_rx, m_has;

  typedef struct { logic [15:0] a; logic [7:0] d; string r; } item_t;
  item_t sb_q[$];

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // drive one cycle at negedge; model follows only when design is not busy
  task automatic drv(bit c, logic [15:0] a, bit dv, logic [7:0] d, bit st, bit w);
    cmd_start_i = c; addr_i = a; data_valid_i = dv; data_i = d; stop_i = st; wp_i = w;
    if (!busy_o) begin
      if (c) begin
        m_rx = 1; m_ptr = a; m_mask = '0; m_has = 0;
      end else if (m_rx) begin
        if (dv) begin
          m_buf[m_ptr[5:0]] = d; m_mask[m_ptr[5:0]] = 1'b1;
          m_ptr[5:0] = m_ptr[5:0] + 6'd1; m_has = 1;
        end
        if (st) begin
          m_rx = 0;
          if (m_has && !w)
            for (int i = 0; i < 64; i++)
              if (m_mask[i]) m_mem[{m_ptr[9:6], 6'(i)}] = m_buf[i];
        end
      end
    end
    @(negedge clk);
    cmd_start_i = 0; data_valid_i = 0; stop_i = 0; wp_i = 0;
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
  endtask

  task automatic push(logic [15:0] a, string r);
    item_t it;
    it.a = a; it.d = m_mem[a[9:0]]; it.r = r;
    sb_q.push_back(it);
  endtask

  // monitor: read back each expected item via address-only commands
  task automatic drain();
    while (sb_q.size() > 0) begin
      item_t it = sb_q.pop_front();
      drv(1, it.a, 0, 0, 0, 0);
      drv(0, 0, 0, 0, 1, 0);
      chk("R11", {31'd0, busy_o}, 32'd0);
      chk("R11", {16'd0, ptr_o}, {16'd0, it.a});
      chk(it.r, {24'd0, rd_data_o}, {24'd0, it.d});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1", {31'd0, busy_o}, 0);
    chk("R1", {16'd0, ptr_o}, 0);

    // single byte
    drv(1, 16'h0105, 0, 0, 0, 0);
    chk("R2", {16'd0, ptr_o}, 32'h0105);
    drv(0, 0, 1, 8'hA5, 0, 0);
    chk("R3", {16'd0, ptr_o}, 32'h0106);
    chk("R6", {31'd0, busy_o}, 0);
    drv(0, 0, 0, 0, 1, 0);
    chk("R7", {31'd0, busy_o}, 1);
    wait_busy(n);
    chk("R7", n, WR);
    chk("R9", {16'd0, ptr_o}, 32'h0106);
    push(16'h0105, "R2");
    drain();

    // full page, then mid-page burst that wraps
    drv(1, 16'h0100, 0, 0, 0, 0);
    for (int i = 0; i < 64; i++) drv(0, 0, 1, 8'(8'h40 + i), 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    wait_busy(n);
    drv(1, 16'h013C, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) drv(0, 0, 1, 8'(8'hC0 + i), 0, 0);
    chk("R5", {16'd0, ptr_o}, 32'h0104);
    drv(0, 0, 0, 0, 1, 0);
    wait_busy(n);
    chk("R9", {16'd0, ptr_o}, 32'h0104);
    for (int i = 0; i < 64; i++) push(16'(16'h0100 + i), (i < 4 || i >= 60) ? "R5" : "R10");
    drain();

    // overflow past 64 bytes
    drv(1, 16'h0200, 0, 0, 0, 0);
    for (int i = 0; i < 70; i++) drv(0, 0, 1, 8'(i), 0, 0);
    chk("R4", {16'd0, ptr_o}, 32'h0206);
    drv(0, 0, 0, 0, 1, 0);
    wait_busy(n);
    for (int i = 0; i < 64; i++) push(16'(16'h0200 + i), "R4");
    drain();

    // protected write dropped
    drv(1, 16'h0200, 0, 0, 0, 0);
    drv(0, 0, 1, 8'hEE, 0, 0);
    drv(0, 0, 0, 0, 1, 1);
    for (int i = 0; i < 3; i++) begin
      chk("R8", {31'd0, busy_o}, 0);
      @(negedge clk);
    end
    push(16'h0200, "R8");
    drain();

    // wp raised after a committing stop
    drv(1, 16'h0280, 0, 0, 0, 0);
    drv(0, 0, 1, 8'h77, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    wp_i = 1;
    wait_busy(n);
    wp_i = 0;
    chk("R8", n, WR);
    push(16'h0280, "R8");
    drain();

    // background for the ignored command
    drv(1, 16'h03F0, 0, 0, 0, 0);
    drv(0, 0, 1, 8'h5A, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    wait_busy(n);

    // byte and stop together, then traffic during busy
    drv(1, 16'h0300, 0, 0, 0, 0);
    drv(0, 0, 1, 8'h11, 0, 0);
    drv(0, 0, 1, 8'h22, 1, 0);
    chk("R13", {16'd0, ptr_o}, 32'h0302);
    chk("R13", {31'd0, busy_o}, 1);
    drv(1, 16'h03F0, 0, 0, 0, 0);
    chk("R12", {16'd0, ptr_o}, 32'h0302);
    drv(0, 0, 1, 8'h99, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    chk("R12", {16'd0, ptr_o}, 32'h0302);
    wait_busy(n);
    chk("R12", {16'd0, ptr_o}, 32'h0302);
    push(16'h0300, "R13");
    push(16'h0301, "R13");
    push(16'h03F0, "R12");
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule